// File: doc/BRIEF.md
# Audio FIFO Status and Interrupt Register

This block is the control and status register for one direction (transmit or receive) of a serial audio port. It watches the FIFO fill level and the event pulses that the serial engine produces, and keeps five event flags. Three of them latch and are cleared by software: word start, frame sync error and FIFO error. Two of them follow live status: FIFO warning and FIFO request. The parameter `IS_TX` picks the direction. For transmit, the FIFO error is an underrun, the warning means the FIFO is empty and the request means the level has fallen to the watermark. For receive, the error is an overflow, the warning means the FIFO is full and the request means the level has risen to the watermark.

Each flag has an interrupt enable, and the interrupt line is the OR of every flag whose enable is set. The register also holds a DMA-request enable, a run (direction enable) bit, a self-clearing FIFO flush command and a software reset. A run bit written to 0 keeps reading 1 until the serial engine reports the end of the current frame. The software reset holds the whole direction cleared for as long as it is set.

Register layout (32 bits): interrupt enables in bits 4:0, flags in bits 12:8, where flag bit 8+i pairs with enable bit i and i is 0 request, 1 warning, 2 FIFO error, 3 sync error, 4 word start. FIFO flush is bit 16, DMA enable is bit 20, software reset is bit 24 and run is bit 31. All other bits read 0.

Top module: `audfifo_csr`

## Requirements
- R1: After reset, `rd_data` is 0 and `irq`, `dma_req`, `fifo_flush`, `dir_reset` and `run` are all 0.
- R2: A one-cycle pulse on `ev_word_start`, `ev_sync_err` or `ev_fifo_err` sets flag bit 12, 11 or 10 at the next clock edge. The flag stays set until a register write with a 1 in that bit position clears it. Writing 0 in that position leaves it unchanged.
- R3: When an event pulse and a write-1 clear of the same flag fall in the same cycle, the flag ends up set.
- R4: The warning flag (bit 9) is live and cannot be cleared by writing. For transmit it reads 1 exactly while `run` is 1 and `fifo_level` is 0. For receive it reads 1 while `run` is 1 and the level equals DEPTH.
- R5: The request flag (bit 8) is live. For transmit it reads 1 while `run` is 1 and `fifo_level` <= `watermark`. For receive it reads 1 while `run` is 1 and `fifo_level` >= `watermark`.
- R6: `irq` is 1 exactly when some flag bit 8+i and its enable bit i are both 1.
- R7: `dma_req` is 1 exactly when DMA enable (bit 20) and the request flag (bit 8) are both 1.
- R8: Writing 1 to bit 16 produces a `fifo_flush` pulse lasting exactly one cycle, in the cycle after the write. Bit 16 always reads 0.
- R9: Writing 1 to bit 31 sets `run` at the next edge. Writing 0 while running leaves `run` at 1 until a later `frame_end` pulse, after which it reads 0.
- R10: While bit 24 is 1, `dir_reset` is 1 and every other field, flag and output stays 0: events and writes to other bits have no effect. A write of 0 to bit 24 releases the direction.
- R11: Writing run=1 again before the frame ends cancels a pending stop. A `frame_end` pulse with no pending stop leaves `run` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register value |
| fifo_level | input | LVL_W | FIFO fill level from the storage |
| watermark | input | LVL_W | Programmed request threshold |
| ev_word_start | input | 1 | Start-of-word pulse from the serial engine |
| ev_sync_err | input | 1 | Frame sync error pulse |
| ev_fifo_err | input | 1 | Underrun (TX) or overflow (RX) pulse |
| frame_end | input | 1 | End-of-frame strobe |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | DMA request |
| fifo_flush | output | 1 | One-cycle FIFO empty command |
| dir_reset | output | 1 | Direction-wide reset, held while bit 24 is set |
| run | output | 1 | Direction enable as seen by the serial engine |

## Verification
The hardest state to reach is a stop that has been requested but not yet carried out. Here `run` still reads 1 after a write of 0, and the outcome depends on whether a `frame_end` arrives or a fresh run write comes first. The bench writes 0, idles for several cycles and checks that `run` holds. It then either pulses `frame_end` or first rewrites run=1 and pulses `frame_end`, checking the different results. The set-beats-clear case is reached by driving an event pulse in the same cycle as a write-1 clear of the same flag.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;

    localparam int REG_W     = 32;
    localparam int NFLAG     = 5;
    localparam int IE_LSB    = 0;
    localparam int FLAG_LSB  = 8;
    localparam int FLUSH_BIT = 16;
    localparam int DMAEN_BIT = 20;
    localparam int SRST_BIT  = 24;
    localparam int RUN_BIT   = 31;

    // flag indices; sticky flags occupy the upper indices
    localparam int FL_REQ    = 0;
    localparam int FL_WARN   = 1;
    localparam int FL_ERR    = 2;
    localparam int FL_SYNC   = 3;
    localparam int FL_WSTART = 4;
    localparam int STICKY_LSB = FL_ERR;
    localparam int NSTICKY    = NFLAG - STICKY_LSB;

    typedef struct packed {
        logic             run;
        logic             srst;
        logic             dma_en;
        logic [NFLAG-1:0] ie;
    } ctl_t;

    function automatic logic [REG_W-1:0] pack_status(ctl_t c, logic [NFLAG-1:0] fl);
        logic [REG_W-1:0] r;
        r = '0;
        r[IE_LSB +: NFLAG]   = c.ie;
        r[FLAG_LSB +: NFLAG] = fl;
        r[DMAEN_BIT]         = c.dma_en;
        r[SRST_BIT]          = c.srst;
        r[RUN_BIT]           = c.run;
        return r;
    endfunction

endpackage

// File: rtl/audfifo_sticky.sv
module audfifo_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || hold)  q[i] <= 1'b0;
            else if (set[i])  q[i] <= 1'b1;   // event beats clear
            else if (clr[i])  q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/audfifo_run_ctl.sv
module audfifo_run_ctl (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic wr_en,
    input  logic wr_run,
    input  logic frame_end,
    output logic run
);
    logic stop_pend;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            run       <= 1'b0;
            stop_pend <= 1'b0;
        end else if (wr_en && wr_run) begin
            run       <= 1'b1;
            stop_pend <= 1'b0;
        end else if (stop_pend && frame_end) begin
            run       <= 1'b0;
            stop_pend <= 1'b0;
        end else if (wr_en && !wr_run && run) begin
            stop_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/audfifo_csr.sv
module audfifo_csr
    import audfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter bit IS_TX = 1'b1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] watermark,
    input  logic             ev_word_start,
    input  logic             ev_sync_err,
    input  logic             ev_fifo_err,
    input  logic             frame_end,
    output logic             irq,
    output logic             dma_req,
    output logic             fifo_flush,
    output logic             dir_reset,
    output logic             run
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic             srst_q;
    logic             hold;
    logic [NFLAG-1:0] ie_q;
    logic             dma_en_q;
    logic             flush_q;
    logic [NSTICKY-1:0] sticky;
    logic             live_req, live_warn;
    logic [NFLAG-1:0] flags;
    ctl_t             ctl;

    // the value being written takes effect at once for the reset hold
    assign hold = wr_en ? wr_data[SRST_BIT] : srst_q;

    always_ff @(posedge clk) begin
        if (rst)        srst_q <= 1'b0;
        else if (wr_en) srst_q <= wr_data[SRST_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            ie_q     <= '0;
            dma_en_q <= 1'b0;
        end else if (wr_en) begin
            ie_q     <= wr_data[IE_LSB +: NFLAG];
            dma_en_q <= wr_data[DMAEN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flush_q <= 1'b0;
        else     flush_q <= wr_en && wr_data[FLUSH_BIT] && !hold;
    end

    audfifo_run_ctl u_run (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .wr_en     (wr_en),
        .wr_run    (wr_data[RUN_BIT]),
        .frame_end (frame_end),
        .run       (run)
    );

    audfifo_sticky #(.N(NSTICKY)) u_sticky (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .set  ({ev_word_start, ev_sync_err, ev_fifo_err}),
        .clr  (wr_en ? wr_data[FLAG_LSB + STICKY_LSB +: NSTICKY] : '0),
        .q    (sticky)
    );

    if (IS_TX) begin : g_tx
        assign live_warn = run && (fifo_level == '0);
        assign live_req  = run && (fifo_level <= watermark);
    end else begin : g_rx
        assign live_warn = run && (fifo_level == FULL_LVL);
        assign live_req  = run && (fifo_level >= watermark);
    end

    assign flags = {sticky, live_warn, live_req};

    assign ctl.run    = run;
    assign ctl.srst   = srst_q;
    assign ctl.dma_en = dma_en_q;
    assign ctl.ie     = ie_q;

    assign rd_data    = pack_status(ctl, flags);
    assign irq        = |(flags & ie_q);
    assign dma_req    = dma_en_q && flags[FL_REQ];
    assign fifo_flush = flush_q;
    assign dir_reset  = srst_q;
endmodule

// File: rtl/audfifo_csr_chk.sv
module audfifo_csr_chk
    import audfifo_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             ev_fifo_err,
    input logic             ev_sync_err,
    input logic             frame_end,
    input logic             irq,
    input logic             dma_req,
    input logic             fifo_flush,
    input logic             dir_reset,
    input logic             run
);
    logic wr_srst;
    assign wr_srst = wr_en && wr_data[SRST_BIT];

    // R3: an event pulse always leaves its flag set, even against a clear
    a_r3_err_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_fifo_err && !wr_srst && !(dir_reset && !wr_en) |=> rd_data[FLAG_LSB + FL_ERR]);
    a_r3_sync_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_sync_err && !wr_srst && !(dir_reset && !wr_en) |=> rd_data[FLAG_LSB + FL_SYNC]);

    // R8: flush pulse only follows a flush write, and the bit reads 0
    a_r8_flush_from_write: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> $past(wr_en && wr_data[FLUSH_BIT]));
    a_r8_flush_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_data[FLUSH_BIT]);

    // R9: run only drops on a frame end or a software reset
    a_r9_hold_until_frame: assert property (@(posedge clk) disable iff (rst)
        run && !frame_end && !wr_srst |=> run);

    // R10: a direction in software reset is silent
    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        dir_reset |-> !irq && !dma_req && !run);

    // R7: DMA request needs both its enable and the request flag
    a_r7_dma_gate: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> rd_data[DMAEN_BIT] && rd_data[FLAG_LSB + FL_REQ]);

    // R6: interrupt implies a flag whose enable is set
    a_r6_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> |(rd_data[FLAG_LSB +: NFLAG] & rd_data[IE_LSB +: NFLAG]));
endmodule

bind audfifo_csr audfifo_csr_chk #(.LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .ev_fifo_err (ev_fifo_err),
    .ev_sync_err (ev_sync_err),
    .frame_end   (frame_end),
    .irq         (irq),
    .dma_req     (dma_req),
    .fifo_flush  (fifo_flush),
    .dir_reset   (dir_reset),
    .run         (run)
);

// File: tb/tb_audfifo_csr.sv
`timescale 1ns/1ps
module tb_audfifo_csr;
    localparam int DEPTH = 32;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [31:0] RUN = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [LVL_W-1:0] fifo_level = LVL_W'(10);
    logic [LVL_W-1:0] watermark  = LVL_W'(4);
    logic ev_word_start = 1'b0, ev_sync_err = 1'b0, ev_fifo_err = 1'b0, frame_end = 1'b0;
    logic irq, dma_req, fifo_flush, dir_reset, run;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    audfifo_csr #(.DEPTH(DEPTH), .IS_TX(1'b1)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .fifo_level(fifo_level), .watermark(watermark),
        .ev_word_start(ev_word_start), .ev_sync_err(ev_sync_err), .ev_fifo_err(ev_fifo_err),
        .frame_end(frame_end), .irq(irq), .dma_req(dma_req), .fifo_flush(fifo_flush),
        .dir_reset(dir_reset), .run(run)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic test_reset;
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 outputs", {27'd0, irq, dma_req, fifo_flush, dir_reset, run}, 32'h0);
    endtask

    task automatic test_sticky;
        ev_fifo_err = 1'b1; @(negedge clk); ev_fifo_err = 1'b0;
        chk("R2 err set", rd_data[10], 1);
        wr(32'h0);
        chk("R2 write0 keeps err", rd_data[10], 1);
        wr(32'h400);
        chk("R2 w1c err", rd_data[10], 0);
        ev_sync_err = 1'b1; ev_word_start = 1'b1; @(negedge clk);
        ev_sync_err = 1'b0; ev_word_start = 1'b0;
        chk("R2 sync+wstart set", rd_data[12:11], 2'b11);
        wr(32'h800);
        chk("R2 clear only sync", rd_data[12:11], 2'b10);
        wr(32'h1000);
        chk("R2 clear wstart", rd_data[12:8], 5'b0);
    endtask

    task automatic test_priority;
        ev_sync_err = 1'b1; wr(32'h800); ev_sync_err = 1'b0;
        chk("R3 set beats clear", rd_data[11], 1);
        wr(32'h800);
        chk("R3 later clear", rd_data[11], 0);
    endtask

    task automatic test_run;
        wr(RUN);
        chk("R9 run set", {31'd0, run}, 1);
        chk("R9 run bit", rd_data[31], 1);
        wr(32'h0);
        idle(3);
        chk("R9 run held after write0", {31'd0, run}, 1);
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        chk("R9 run cleared at frame end", {31'd0, run}, 0);
        wr(RUN); wr(32'h0); wr(RUN);
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        chk("R11 rewrite cancels stop", {31'd0, run}, 1);
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        chk("R11 frame end no pending", {31'd0, run}, 1);
    endtask

    task automatic test_live;
        chk("R5 no req at level 10", rd_data[9:8], 2'b00);
        fifo_level = LVL_W'(4); @(negedge clk);
        chk("R5 req at watermark", rd_data[9:8], 2'b01);
        fifo_level = LVL_W'(0); @(negedge clk);
        chk("R4 warn when empty", rd_data[9:8], 2'b11);
        wr(RUN | 32'h200);
        chk("R4 warn not cleared by write", rd_data[9], 1);
        fifo_level = LVL_W'(10); @(negedge clk);
        chk("R4 warn follows level", rd_data[9:8], 2'b00);
    endtask

    task automatic test_irq;
        ev_fifo_err = 1'b1; @(negedge clk); ev_fifo_err = 1'b0;
        chk("R6 no irq without enable", {31'd0, irq}, 0);
        wr(RUN | 32'h4);
        chk("R6 irq err enabled", {31'd0, irq}, 1);
        wr(RUN | 32'h8);
        chk("R6 mismatched enable", {31'd0, irq}, 0);
        fifo_level = LVL_W'(4);
        wr(RUN | 32'h1);
        chk("R6 irq from request", {31'd0, irq}, 1);
        wr(RUN | 32'h400);
        fifo_level = LVL_W'(10); @(negedge clk);
        chk("R6 irq idle", {31'd0, irq}, 0);
    endtask

    task automatic test_dma;
        fifo_level = LVL_W'(4); @(negedge clk);
        chk("R7 no dma without enable", {31'd0, dma_req}, 0);
        wr(RUN | 32'h10_0000);
        chk("R7 dma request", {31'd0, dma_req}, 1);
        fifo_level = LVL_W'(10); @(negedge clk);
        chk("R7 dma drops above watermark", {31'd0, dma_req}, 0);
    endtask

    task automatic test_flush;
        chk("R8 flush idle", {31'd0, fifo_flush}, 0);
        wr(RUN | 32'h1_0000);
        chk("R8 flush pulse", {31'd0, fifo_flush}, 1);
        chk("R8 flush reads 0", rd_data[16], 0);
        @(negedge clk);
        chk("R8 flush one cycle", {31'd0, fifo_flush}, 0);
    endtask

    task automatic test_srst;
        ev_fifo_err = 1'b1; @(negedge clk); ev_fifo_err = 1'b0;
        wr(RUN | 32'h10_0004);
        chk("R10 pre irq", {31'd0, irq}, 1);
        wr(32'h100_0000);
        chk("R10 rd in reset", rd_data, 32'h100_0000);
        chk("R10 outputs in reset", {28'd0, irq, dma_req, dir_reset, run}, 32'h2);
        ev_fifo_err = 1'b1; @(negedge clk); ev_fifo_err = 1'b0;
        chk("R10 event ignored", rd_data, 32'h100_0000);
        wr(32'h8110_001F);
        chk("R10 write ignored", rd_data, 32'h100_0000);
        wr(32'h0);
        chk("R10 released", rd_data, 32'h0);
        chk("R10 dir_reset low", {31'd0, dir_reset}, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        test_reset;
        test_sticky;
        test_priority;
        test_run;
        test_live;
        test_irq;
        test_dma;
        test_flush;
        test_srst;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule